// File: doc/BRIEF.md
# Receive Buffer Flow Control

This block watches how much room is left in a receive packet buffer and turns that into flow-control requests for the transmit side of an Ethernet MAC. In full or half duplex it asks for pause frames: a maximum-time pause (0xFFFF) when the free space falls under a high watermark, and a zero-time pause that lets traffic resume once the free space has grown past a low watermark. Software can also ask for either pause frame directly. Each software request stays set until the transmitter acknowledges that frame.

In half duplex the block can also apply back-pressure. It raises a congestion (jam) signal when a new frame starts to arrive while the buffer is short of room. In one mode any frame triggers it; in the other mode only a frame whose destination address matches does. The congestion window lasts for a time picked by a 4-bit code from a non-linear table. A clock-cycles-per-microsecond parameter converts that time into clock cycles.

The surrounding register file holds the configuration fields. Their suggested reset values are a high mark of 3, a low mark of 8 and a duration code of 7, and they are exported from the package. The block does not build the pause frame, apply MAC timing or manage the buffer.

Top module: `rx_flow_ctrl`

## Requirements
- R1: With automatic pausing enabled, no request outstanding and no full-time pause already sent, free space below `hi_mark`*1024 bytes raises `pause_req` one cycle later with `pause_time` = 0xFFFF.
- R2: A zero-time automatic request (`pause_time` = 0x0000) is raised only when the most recently acknowledged pause frame carried 0xFFFF and the free space is above `lo_mark`*1024 bytes.
- R3: Automatic pause requests are made only while `flow_en` and `auto_pause_en` are both 1.
- R4: A mark value of 0 disables the action of that threshold (high pause, low resume, or back-pressure).
- R5: A pulse on `sw_max_set` or `sw_zero_set` sets `sw_max_pend` or `sw_zero_pend` in the next cycle. A pending bit launches a request with 0xFFFF or 0x0000. The bit clears when that request is acknowledged. Launch priority is software 0xFFFF, then software 0x0000, then automatic high, then automatic low.
- R6: Only one request is outstanding. `pause_req` and `pause_time` hold until `pause_ack`, and `pause_req` is low in the cycle after an acknowledge.
- R7: In half duplex (`full_duplex`=0), `frame_start` with free space below `bp_mark`*1024 asserts `jam_active` in the next cycle. This happens when `bp_any_en`=1, or when `bp_match_en`=1 and `dest_match`=1.
- R8: In full duplex no congestion window starts, and a running window ends in the next cycle.
- R9: The window lasts exactly D*CYC_PER_US cycles. D in microseconds is 5, 10, 15, 25 for codes 0 to 3, and 50*(code-3) for codes 4 to 15.
- R10: A running window is not restarted or extended by further triggering frames.
- R11: After reset `pause_req`, `pause_time`, both pending bits and `jam_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| free_bytes | input | FREE_W | Free bytes in the receive buffer |
| hi_mark | input | 4 | High watermark, KB units |
| lo_mark | input | 4 | Low watermark, KB units |
| bp_mark | input | 4 | Back-pressure threshold, KB units |
| jam_code | input | 4 | Congestion duration code |
| flow_en | input | 1 | Flow control enable |
| auto_pause_en | input | 1 | Automatic pause generation enable |
| bp_any_en | input | 1 | Back-pressure on any arriving frame |
| bp_match_en | input | 1 | Back-pressure on address-matching frames |
| full_duplex | input | 1 | Link is full duplex |
| frame_start | input | 1 | Strobe: new frame arriving |
| dest_match | input | 1 | Strobe: that frame's destination matches |
| sw_max_set | input | 1 | Software request for a 0xFFFF pause |
| sw_zero_set | input | 1 | Software request for a 0x0000 pause |
| pause_ack | input | 1 | Transmitter has sent the requested pause frame |
| pause_req | output | 1 | Pause frame request |
| pause_time | output | 16 | Pause time of the request |
| sw_max_pend | output | 1 | Software 0xFFFF request pending |
| sw_zero_pend | output | 1 | Software 0x0000 request pending |
| jam_active | output | 1 | Congestion (jam) window active |

## Verification
The assertions check the handshake rules on every cycle: the request and its time stay stable until acknowledged, and a gap follows each acknowledge. They also check that a pending software bit holds until its own frame is sent, and that automatic launches happen only with both enables set. On the congestion side they check that a resume launch is preceded by a full-time pause, that full duplex ends the window at once, and that the remaining time never grows. The exact window length for each duration code, the hysteresis sequence across both watermarks, the launch priority when several sources want the channel, and the address-match mode can only be shown by the bench scenarios, compared against a cycle model built from the requirements.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [1:0] {
    SRC_SW_MAX  = 2'd0,
    SRC_SW_ZERO = 2'd1,
    SRC_AUTO_HI = 2'd2,
    SRC_AUTO_LO = 2'd3
  } pause_src_e;

  localparam logic [15:0] PAUSE_FULL = 16'hFFFF;
  localparam logic [15:0] PAUSE_NONE = 16'h0000;

  // Suggested reset values for the configuration register file
  localparam logic [3:0] HI_MARK_RST  = 4'd3;
  localparam logic [3:0] LO_MARK_RST  = 4'd8;
  localparam logic [3:0] JAM_CODE_RST = 4'd7;

  localparam int US_W = 10;

  // Congestion duration in microseconds for a 4-bit code
  function automatic logic [US_W-1:0] jam_us(input logic [3:0] code);
    logic [US_W-1:0] c;
    c = US_W'(code);
    if (code < 4'd3)       jam_us = US_W'(5) * (c + US_W'(1));
    else if (code == 4'd3) jam_us = US_W'(25);
    else                   jam_us = US_W'(50) * (c - US_W'(3));
  endfunction

endpackage

// File: rtl/rfc_level_cmp.sv
module rfc_level_cmp #(
  parameter int FREE_W    = 16,
  parameter int MARK_W    = 4,
  parameter int UNIT_LOG2 = 10,
  parameter bit ABOVE     = 1'b0
) (
  input  logic [FREE_W-1:0] free_bytes,
  input  logic [MARK_W-1:0] mark,
  output logic              hit
);
  localparam int THR_W = MARK_W + UNIT_LOG2;
  localparam int CMP_W = (FREE_W > THR_W) ? FREE_W : THR_W;

  logic [CMP_W-1:0] thr;
  logic [CMP_W-1:0] fre;
  logic             enabled;

  assign thr     = CMP_W'({mark, {UNIT_LOG2{1'b0}}});
  assign fre     = CMP_W'(free_bytes);
  assign enabled = |mark;

  generate
    if (ABOVE) begin : g_above
      assign hit = enabled && (fre > thr);
    end else begin : g_below
      assign hit = enabled && (fre < thr);
    end
  endgenerate

endmodule

// File: rtl/rfc_pause_arb.sv
module rfc_pause_arb
  import rfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        auto_on,
  input  logic        below_hi,
  input  logic        above_lo,
  input  logic        sw_max_set,
  input  logic        sw_zero_set,
  input  logic        pause_ack,
  output logic        pause_req,
  output logic [15:0] pause_time,
  output logic        sw_max_pend,
  output logic        sw_zero_pend
);
  logic        req_q, req_d;
  logic [15:0] time_q, time_d;
  pause_src_e  src_q, src_d;
  logic        paused_q, paused_d;
  logic        smax_q, smax_d;
  logic        szero_q, szero_d;
  logic        ack_ok;
  logic        smax_clr, szero_clr;
  logic        launch_en;

  assign ack_ok    = req_q & pause_ack;
  assign smax_clr  = ack_ok & (src_q == SRC_SW_MAX);
  assign szero_clr = ack_ok & (src_q == SRC_SW_ZERO);

  always_comb begin
    req_d     = req_q;
    time_d    = time_q;
    src_d     = src_q;
    paused_d  = paused_q;
    launch_en = 1'b0;
    if (ack_ok) begin
      req_d    = 1'b0;
      paused_d = (time_q == PAUSE_FULL);
    end else if (!req_q) begin
      launch_en = 1'b1;
      if (smax_q) begin
        req_d = 1'b1; time_d = PAUSE_FULL; src_d = SRC_SW_MAX;
      end else if (szero_q) begin
        req_d = 1'b1; time_d = PAUSE_NONE; src_d = SRC_SW_ZERO;
      end else if (auto_on && below_hi && !paused_q) begin
        req_d = 1'b1; time_d = PAUSE_FULL; src_d = SRC_AUTO_HI;
      end else if (auto_on && above_lo && paused_q) begin
        req_d = 1'b1; time_d = PAUSE_NONE; src_d = SRC_AUTO_LO;
      end else begin
        launch_en = 1'b0;
      end
    end
    smax_d  = (smax_q  & ~smax_clr)  | sw_max_set;
    szero_d = (szero_q & ~szero_clr) | sw_zero_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      paused_q <= 1'b0;
      smax_q   <= 1'b0;
      szero_q  <= 1'b0;
    end else begin
      req_q    <= req_d;
      paused_q <= paused_d;
      smax_q   <= smax_d;
      szero_q  <= szero_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= PAUSE_NONE;
      src_q  <= SRC_SW_MAX;
    end else if (launch_en) begin
      time_q <= time_d;
      src_q  <= src_d;
    end
  end

  assign pause_req    = req_q;
  assign pause_time   = time_q;
  assign sw_max_pend  = smax_q;
  assign sw_zero_pend = szero_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !pause_ack) |=> (req_q && $stable(time_q)));

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && pause_ack) |=> !req_q);

  p_resume_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_q) && time_q == PAUSE_NONE && !$past(szero_q)) |-> $past(paused_q));

  p_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_q) && time_q == PAUSE_FULL && !$past(smax_q)) |-> $past(below_hi));

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_q) && !$past(smax_q) && !$past(szero_q)) |-> $past(auto_on));

  p_swhold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smax_q && !(req_q && pause_ack && src_q == SRC_SW_MAX)) |=> smax_q);

endmodule

// File: rtl/rfc_jam_timer.sv
module rfc_jam_timer
  import rfc_pkg::*;
#(
  parameter int CYC_PER_US = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       full_duplex,
  input  logic       trigger,
  input  logic [3:0] code,
  output logic       jam_active
);
  localparam int CYC_W = $clog2(CYC_PER_US + 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_US - 1);

  logic             act_q, act_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [US_W-1:0]  us_q, us_d;

  always_comb begin
    act_d = act_q;
    cyc_d = cyc_q;
    us_d  = us_q;
    if (full_duplex) begin
      act_d = 1'b0;
      cyc_d = '0;
      us_d  = '0;
    end else if (act_q) begin
      if (cyc_q == CYC_LAST) begin
        cyc_d = '0;
        us_d  = us_q - US_W'(1);
        if (us_q == US_W'(1)) act_d = 1'b0;
      end else begin
        cyc_d = cyc_q + CYC_W'(1);
      end
    end else if (trigger) begin
      act_d = 1'b1;
      cyc_d = '0;
      us_d  = jam_us(code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cyc_q <= '0;
      us_q  <= '0;
    end else begin
      act_q <= act_d;
      cyc_q <= cyc_d;
      us_q  <= us_d;
    end
  end

  assign jam_active = act_q;

  p_fdx_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |=> !act_q);

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && !act_q && !full_duplex) |=> act_q);

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> (us_q <= $past(us_q)));

  p_time_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (us_q != '0));

endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
  import rfc_pkg::*;
#(
  parameter int FREE_W     = 16,
  parameter int UNIT_LOG2  = 10,
  parameter int CYC_PER_US = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREE_W-1:0] free_bytes,
  input  logic [3:0]        hi_mark,
  input  logic [3:0]        lo_mark,
  input  logic [3:0]        bp_mark,
  input  logic [3:0]        jam_code,
  input  logic              flow_en,
  input  logic              auto_pause_en,
  input  logic              bp_any_en,
  input  logic              bp_match_en,
  input  logic              full_duplex,
  input  logic              frame_start,
  input  logic              dest_match,
  input  logic              sw_max_set,
  input  logic              sw_zero_set,
  input  logic              pause_ack,
  output logic              pause_req,
  output logic [15:0]       pause_time,
  output logic              sw_max_pend,
  output logic              sw_zero_pend,
  output logic              jam_active
);
  localparam int N_MARKS = 3;
  localparam int IDX_HI  = 0;
  localparam int IDX_LO  = 1;
  localparam int IDX_BP  = 2;

  logic [3:0]         mark_v [N_MARKS];
  logic [N_MARKS-1:0] hit_v;
  logic               auto_on;
  logic               jam_trig;

  assign mark_v[IDX_HI] = hi_mark;
  assign mark_v[IDX_LO] = lo_mark;
  assign mark_v[IDX_BP] = bp_mark;

  generate
    for (genvar i = 0; i < N_MARKS; i++) begin : g_cmp
      rfc_level_cmp #(
        .FREE_W   (FREE_W),
        .MARK_W   (4),
        .UNIT_LOG2(UNIT_LOG2),
        .ABOVE    (i == IDX_LO)
      ) u_cmp (
        .free_bytes(free_bytes),
        .mark      (mark_v[i]),
        .hit       (hit_v[i])
      );
    end
  endgenerate

  assign auto_on  = flow_en & auto_pause_en;
  assign jam_trig = frame_start & hit_v[IDX_BP] & ~full_duplex &
                    (bp_any_en | (bp_match_en & dest_match));

  rfc_pause_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_on     (auto_on),
    .below_hi    (hit_v[IDX_HI]),
    .above_lo    (hit_v[IDX_LO]),
    .sw_max_set  (sw_max_set),
    .sw_zero_set (sw_zero_set),
    .pause_ack   (pause_ack),
    .pause_req   (pause_req),
    .pause_time  (pause_time),
    .sw_max_pend (sw_max_pend),
    .sw_zero_pend(sw_zero_pend)
  );

  rfc_jam_timer #(
    .CYC_PER_US(CYC_PER_US)
  ) u_jam (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_duplex(full_duplex),
    .trigger    (jam_trig),
    .code       (jam_code),
    .jam_active (jam_active)
  );

  p_jam_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> ($past(frame_start) && !$past(full_duplex)));

  p_hi_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_mark == 4'd0) |-> !hit_v[IDX_HI]);

endmodule

// File: tb/tb_rx_flow_ctrl.sv
module tb_rx_flow_ctrl;
  localparam int CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] free_bytes = '0;
  logic [3:0]  hi_mark = 4'd3, lo_mark = 4'd8, bp_mark = 4'd0, jam_code = 4'd7;
  logic        flow_en = 0, auto_pause_en = 0, bp_any_en = 0, bp_match_en = 0;
  logic        full_duplex = 0, frame_start = 0, dest_match = 0;
  logic        sw_max_set = 0, sw_zero_set = 0, pause_ack = 0;
  logic        pause_req, sw_max_pend, sw_zero_pend, jam_active;
  logic [15:0] pause_time;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rx_flow_ctrl #(.FREE_W(16), .UNIT_LOG2(10), .CYC_PER_US(CYC)) dut (
    .clk(clk), .rst_n(rst_n), .free_bytes(free_bytes), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .bp_mark(bp_mark), .jam_code(jam_code), .flow_en(flow_en),
    .auto_pause_en(auto_pause_en), .bp_any_en(bp_any_en), .bp_match_en(bp_match_en),
    .full_duplex(full_duplex), .frame_start(frame_start), .dest_match(dest_match),
    .sw_max_set(sw_max_set), .sw_zero_set(sw_zero_set), .pause_ack(pause_ack),
    .pause_req(pause_req), .pause_time(pause_time), .sw_max_pend(sw_max_pend),
    .sw_zero_pend(sw_zero_pend), .jam_active(jam_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dur_us(input int code);
    case (code)
      0: return 5;    1: return 10;   2: return 15;   3: return 25;
      4: return 50;   5: return 100;  6: return 150;  7: return 200;
      8: return 250;  9: return 300;  10: return 350; 11: return 400;
      12: return 450; 13: return 500; 14: return 550; default: return 600;
    endcase
  endfunction

  // Reference cycle model built from the requirements
  logic m_req, m_paused, m_smax, m_szero, m_jam;
  logic [15:0] m_time;
  int m_src, m_cyc, m_us;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_paused = 0; m_smax = 0; m_szero = 0; m_jam = 0;
      m_time = 16'h0; m_src = 0; m_cyc = 0; m_us = 0;
    end else begin
      automatic bit on  = flow_en && auto_pause_en;
      automatic bit bhi = (hi_mark != 0) && (int'(free_bytes) < int'(hi_mark) * 1024);
      automatic bit alo = (lo_mark != 0) && (int'(free_bytes) > int'(lo_mark) * 1024);
      automatic bit bbp = (bp_mark != 0) && (int'(free_bytes) < int'(bp_mark) * 1024);
      automatic bit ack = m_req && pause_ack;
      automatic bit nsmax  = (m_smax  && !(ack && m_src == 0)) || sw_max_set;
      automatic bit nszero = (m_szero && !(ack && m_src == 1)) || sw_zero_set;
      if (ack) begin
        m_req = 0;
        m_paused = (m_time == 16'hFFFF);
      end else if (!m_req) begin
        if (m_smax)                         begin m_req = 1; m_time = 16'hFFFF; m_src = 0; end
        else if (m_szero)                   begin m_req = 1; m_time = 16'h0000; m_src = 1; end
        else if (on && bhi && !m_paused)    begin m_req = 1; m_time = 16'hFFFF; m_src = 2; end
        else if (on && alo && m_paused)     begin m_req = 1; m_time = 16'h0000; m_src = 3; end
      end
      m_smax = nsmax; m_szero = nszero;
      if (full_duplex) m_jam = 0;
      else if (m_jam) begin
        if (m_cyc == CYC - 1) begin
          m_cyc = 0; m_us--;
          if (m_us == 0) m_jam = 0;
        end else m_cyc++;
      end else if (frame_start && bbp && (bp_any_en || (bp_match_en && dest_match))) begin
        m_jam = 1; m_cyc = 0; m_us = dur_us(int'(jam_code));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 model pause_req", int'(pause_req), int'(m_req));
      chk("R1 model pause_time", int'(pause_time), int'(m_time));
      chk("R5 model sw_max_pend", int'(sw_max_pend), int'(m_smax));
      chk("R5 model sw_zero_pend", int'(sw_zero_pend), int'(m_szero));
      chk("R9 model jam_active", int'(jam_active), int'(m_jam));
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack_now();
    pause_ack = 1; step(); pause_ack = 0;
  endtask

  task automatic measure_jam(input int code, input int retrig_at, input string tag);
    int cnt = 0;
    jam_code = 4'(code);
    frame_start = 1; step(); frame_start = 0;
    while (jam_active && cnt < 5000) begin
      cnt++;
      frame_start = (cnt == retrig_at);
      step();
    end
    frame_start = 0;
    chk(tag, cnt, dur_us(code) * CYC);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'h1F2E3D4C));
    step(3);
    rst_n = 1;
    step();
    // R11 reset state
    chk("R11 pause_req", int'(pause_req), 0);
    chk("R11 pause_time", int'(pause_time), 0);
    chk("R11 sw_max_pend", int'(sw_max_pend), 0);
    chk("R11 sw_zero_pend", int'(sw_zero_pend), 0);
    chk("R11 jam_active", int'(jam_active), 0);

    // R1 / R6 / R2 hysteresis
    free_bytes = 16'd5000; flow_en = 1; auto_pause_en = 1;
    step(2);
    chk("R1 no pause between marks", int'(pause_req), 0);
    free_bytes = 16'd2000; step();
    chk("R1 pause raised", int'(pause_req), 1);
    chk("R1 pause time full", int'(pause_time), 16'hFFFF);
    step(3);
    chk("R6 held without ack", int'(pause_req), 1);
    ack_now();
    chk("R6 low after ack", int'(pause_req), 0);
    step(4);
    chk("R2 no repeat while paused", int'(pause_req), 0);
    free_bytes = 16'd8192; step(2);
    chk("R2 no resume at exactly low mark", int'(pause_req), 0);
    free_bytes = 16'd9000; step();
    chk("R2 resume raised", int'(pause_req), 1);
    chk("R2 resume time zero", int'(pause_time), 0);
    ack_now(); step(3);
    chk("R2 no second resume", int'(pause_req), 0);

    // R3 gating
    auto_pause_en = 0; free_bytes = 16'd1000; step(4);
    chk("R3 auto off no pause", int'(pause_req), 0);
    auto_pause_en = 1; flow_en = 0; step(4);
    chk("R3 flow off no pause", int'(pause_req), 0);
    // R4 zero high mark
    flow_en = 1; hi_mark = 4'd0; free_bytes = 16'd0; step(4);
    chk("R4 zero mark no pause", int'(pause_req), 0);
    hi_mark = 4'd3; flow_en = 0; free_bytes = 16'd5000; step();

    // R5 software requests and priority
    sw_max_set = 1; sw_zero_set = 1; step();
    sw_max_set = 0; sw_zero_set = 0;
    chk("R5 max bit set", int'(sw_max_pend), 1);
    chk("R5 zero bit set", int'(sw_zero_pend), 1);
    step();
    chk("R5 max first", int'(pause_time), 16'hFFFF);
    ack_now();
    chk("R5 max bit cleared", int'(sw_max_pend), 0);
    chk("R5 zero bit kept", int'(sw_zero_pend), 1);
    step();
    chk("R5 zero second", int'(pause_req) * 65536 + int'(pause_time), 65536);
    ack_now();
    chk("R5 zero bit cleared", int'(sw_zero_pend), 0);

    // Back-pressure
    free_bytes = 16'd1000; bp_mark = 4'd4; bp_any_en = 1;
    measure_jam(0, -1, "R9 code 0");
    measure_jam(3, -1, "R9 code 3");
    measure_jam(7, -1, "R9 code 7");
    measure_jam(15, -1, "R9 code 15");
    measure_jam(2, 20, "R10 no restart");
    bp_mark = 4'd0; frame_start = 1; step(); frame_start = 0;
    chk("R4 zero bp mark", int'(jam_active), 0);
    bp_mark = 4'd4; bp_any_en = 0; bp_match_en = 1;
    frame_start = 1; dest_match = 0; step(); frame_start = 0;
    chk("R7 no match no jam", int'(jam_active), 0);
    frame_start = 1; dest_match = 1; step(); frame_start = 0; dest_match = 0;
    chk("R7 match jam", int'(jam_active), 1);
    step(3);
    full_duplex = 1; step();
    chk("R8 full duplex stops jam", int'(jam_active), 0);
    frame_start = 1; dest_match = 1; step(); frame_start = 0; dest_match = 0;
    chk("R8 full duplex no jam", int'(jam_active), 0);
    full_duplex = 0; step();

    // Random phase against the model
    lat = 0;
    for (int c = 0; c < 6000; c++) begin
      if (c % 300 == 0) begin
        hi_mark = 4'($urandom_range(0, 5));
        lo_mark = 4'($urandom_range(0, 10));
        bp_mark = 4'($urandom_range(0, 6));
        jam_code = 4'($urandom_range(0, 4));
        flow_en = ($urandom_range(0, 9) != 0);
        auto_pause_en = ($urandom_range(0, 9) != 0);
        bp_any_en = $urandom_range(0, 1);
        bp_match_en = $urandom_range(0, 1);
      end
      if (c % 37 == 0) free_bytes = 16'($urandom_range(0, 12000));
      full_duplex = ($urandom_range(0, 199) == 0);
      frame_start = ($urandom_range(0, 7) == 0);
      dest_match = $urandom_range(0, 1);
      sw_max_set = ($urandom_range(0, 99) == 0);
      sw_zero_set = ($urandom_range(0, 99) == 0);
      pause_ack = ($urandom_range(0, 3) == 0);
      step();
    end
    frame_start = 0; sw_max_set = 0; sw_zero_set = 0; pause_ack = 0; full_duplex = 0;
    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule